// File: doc/BRIEF.md
# Edge-Capturing GPIO Controller

A 32-pin general-purpose I/O controller on a simple register bus. Each pin has a direction, an open-drain select and a data latch. The read path for the data register returns the latch for output pins and the synchronized pad level for input pins. Each pin also has an event bit that captures edges on the synchronized input, an interrupt enable bit and an edge-mode bit. One level interrupt output stays high while any enabled event is pending.

The bus transfers a full word in a single cycle. A write takes effect at the clock edge where `req_i && we_i` is high. Read data is combinational from `addr_i` in the same cycle. In every register, pin n occupies bit (31 - n), so pin 0 is the most significant bit. The pin-side ports are indexed by pin number: `pin_i[n]` is pin n.

Top module: `gpio_ctl`

## Requirements
- R1: After reset every register reads zero, `pin_oe_o` is all zero and `irq_o` is low.
- R2: Pin n corresponds to register bit (31 - n) in every register. `pin_i`, `pin_o` and `pin_oe_o` are indexed by pin number.
- R3: A direction bit of 1 makes the pin an output. With its open-drain bit at 0, the pin drives `pin_oe_o`=1 and `pin_o` equal to its data latch bit. A direction bit of 0 holds `pin_oe_o` low.
- R4: An output pin with its open-drain bit at 1 never drives high (`pin_o`=0). A latch bit of 0 gives `pin_oe_o`=1 and a latch bit of 1 gives `pin_oe_o`=0.
- R5: Registers sit at byte addresses 0x00 direction, 0x04 open-drain, 0x08 data, 0x0C event, 0x10 interrupt enable and 0x14 edge mode. A read of 0x08 returns the latch for output pins and the synchronized pad level for input pins.
- R6: A pad change applied before clock edge k becomes visible in the data read-back after edge k+1. Its event is set after edge k+2.
- R7: Edge-mode bit 1 captures falling edges only. Edge-mode bit 0 captures both rising and falling edges.
- R8: Writing 0x0C clears every event bit written as 1 and leaves bits written as 0 unchanged.
- R9: When an edge and a clearing write hit the same event bit in the same cycle, the bit stays set.
- R10: `irq_o` is high exactly when some event bit and its interrupt enable bit are both 1.
- R11: Addresses other than the six listed read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access in this cycle |
| we_i | input | 1 | Access is a write |
| addr_i | input | 5 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| pin_i | input | 32 | Pad input levels, by pin number |
| pin_o | output | 32 | Pad output values, by pin number |
| pin_oe_o | output | 32 | Pad output enables, by pin number |
| irq_o | output | 1 | Combined interrupt |

## Verification
The assertions check four things on every cycle:
- An event bit never drops unless a clearing write covered it.
- A new event appears only where the synchronized samples show an edge allowed by the pin's edge mode.
- No enable is asserted on a non-output pin, and no open-drain pin drives a 1.
- Unmapped writes leave the configuration untouched.

Only the bench scenarios can show the exact two-edge synchronizer latency and the bit reversal between pin numbers and register bits. The same holds for the result when an edge and a clear collide on a bit and for the read-back mux choosing latch against pad. The bench shows these by comparing a behavioural model against the design every cycle and through directed checks.

// File: rtl/gpio_ctl_pkg.sv
`timescale 1ns/1ps
package gpio_ctl_pkg;
  localparam int unsigned ADDR_W = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_DIR = 5'h00,
    A_ODR = 5'h04,
    A_DAT = 5'h08,
    A_EVT = 5'h0C,
    A_MSK = 5'h10,
    A_EDG = 5'h14
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer plus one history stage, per bit.
module gpio_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] sync_o,
  output logic [W-1:0] prev_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic s1_q, s2_q, p_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        p_q  <= 1'b0;
      end else begin
        s1_q <= raw_i[b];
        s2_q <= s1_q;
        p_q  <= s2_q;
      end
    end
    assign sync_o[b] = s2_q;
    assign prev_o[b] = p_q;
  end
endmodule

// File: rtl/gpio_edge.sv
`timescale 1ns/1ps
module gpio_edge #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] prev_i,
  input  logic [W-1:0] fall_only_i,
  output logic [W-1:0] det_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic rise, fall;
    assign rise     = sync_i[b] & ~prev_i[b];
    assign fall     = ~sync_i[b] & prev_i[b];
    assign det_o[b] = fall | (rise & ~fall_only_i[b]);
  end
endmodule

// File: rtl/gpio_regs.sv
`timescale 1ns/1ps
module gpio_regs
  import gpio_ctl_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic [W-1:0]      sync_i,
  input  logic [W-1:0]      det_i,
  output logic [W-1:0]      rdata_o,
  output logic [W-1:0]      dir_o,
  output logic [W-1:0]      odr_o,
  output logic [W-1:0]      dat_o,
  output logic [W-1:0]      ev_o,
  output logic [W-1:0]      msk_o,
  output logic [W-1:0]      edg_o
);
  logic          wr;
  logic [W-1:0]  clr;

  assign wr  = req_i & we_i;
  assign clr = (wr && addr_i == A_EVT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= '0;
      odr_o <= '0;
      dat_o <= '0;
      msk_o <= '0;
      edg_o <= '0;
    end else if (wr) begin
      case (addr_i)
        A_DIR:   dir_o <= wdata_i;
        A_ODR:   odr_o <= wdata_i;
        A_DAT:   dat_o <= wdata_i;
        A_MSK:   msk_o <= wdata_i;
        A_EDG:   edg_o <= wdata_i;
        default: ;
      endcase
    end
  end

  // a fresh edge outranks a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_o <= '0;
    else         ev_o <= (ev_o & ~clr) | det_i;
  end

  always_comb begin
    case (addr_i)
      A_DIR:   rdata_o = dir_o;
      A_ODR:   rdata_o = odr_o;
      A_DAT:   rdata_o = (dat_o & dir_o) | (sync_i & ~dir_o);
      A_EVT:   rdata_o = ev_o;
      A_MSK:   rdata_o = msk_o;
      A_EDG:   rdata_o = edg_o;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_pad.sv
`timescale 1ns/1ps
// Register-bit domain in, pin-number domain out.
module gpio_pad #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] odr_i,
  input  logic [W-1:0] dat_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o
);
  for (genvar n = 0; n < W; n++) begin : g_pin
    localparam int unsigned B = W - 1 - n;
    assign pin_o[n]    = odr_i[B] ? 1'b0 : dat_i[B];
    assign pin_oe_o[n] = dir_i[B] & (odr_i[B] ? ~dat_i[B] : 1'b1);
  end
endmodule

// File: rtl/gpio_ctl.sv
`timescale 1ns/1ps
module gpio_ctl
  import gpio_ctl_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_oe_o,
  output logic              irq_o
);
  logic [NPINS-1:0] raw_bits, sync_q, prev_q, det;
  logic [NPINS-1:0] dir_q, odr_q, dat_q, ev_q, msk_q, edg_q;

  for (genvar n = 0; n < NPINS; n++) begin : g_rev
    assign raw_bits[NPINS-1-n] = pin_i[n];
  end

  gpio_sync #(.W(NPINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (raw_bits),
    .sync_o (sync_q),
    .prev_o (prev_q)
  );

  gpio_edge #(.W(NPINS)) u_edge (
    .sync_i      (sync_q),
    .prev_i      (prev_q),
    .fall_only_i (edg_q),
    .det_o       (det)
  );

  gpio_regs #(.W(NPINS)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_i),
    .we_i    (we_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .sync_i  (sync_q),
    .det_i   (det),
    .rdata_o (rdata_o),
    .dir_o   (dir_q),
    .odr_o   (odr_q),
    .dat_o   (dat_q),
    .ev_o    (ev_q),
    .msk_o   (msk_q),
    .edg_o   (edg_q)
  );

  gpio_pad #(.W(NPINS)) u_pad (
    .dir_i    (dir_q),
    .odr_i    (odr_q),
    .dat_i    (dat_q),
    .pin_o    (pin_o),
    .pin_oe_o (pin_oe_o)
  );

  assign irq_o = |(ev_q & msk_q);
endmodule

// File: rtl/gpio_ctl_chk.sv
`timescale 1ns/1ps
module gpio_ctl_chk
  import gpio_ctl_pkg::*;
#(
  parameter int unsigned NPINS = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NPINS-1:0]  wdata_i,
  input logic [NPINS-1:0]  pin_o,
  input logic [NPINS-1:0]  pin_oe_o,
  input logic              irq_o,
  input logic [NPINS-1:0]  sync_q,
  input logic [NPINS-1:0]  prev_q,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  odr_q,
  input logic [NPINS-1:0]  dat_q,
  input logic [NPINS-1:0]  ev_q,
  input logic [NPINS-1:0]  msk_q,
  input logic [NPINS-1:0]  edg_q
);
  logic [NPINS-1:0] dir_pin, odr_pin, clr_vec, allowed;
  logic             bad_wr;

  for (genvar n = 0; n < NPINS; n++) begin : g_rev
    assign dir_pin[n] = dir_q[NPINS-1-n];
    assign odr_pin[n] = odr_q[NPINS-1-n];
  end

  assign clr_vec = (req_i && we_i && addr_i == A_EVT) ? wdata_i : '0;
  assign allowed = (prev_q & ~sync_q) | (~prev_q & sync_q & ~edg_q);
  assign bad_wr  = req_i && we_i &&
                   !(addr_i inside {A_DIR, A_ODR, A_DAT, A_EVT, A_MSK, A_EDG});

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_zero_chk: assert (pin_oe_o == '0 && irq_o == 1'b0 && ev_q == '0);
    end
  end

  // R8
  ev_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(ev_q) & ~$past(clr_vec)) & ~ev_q) == '0);

  // R7
  ev_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ev_q & ~$past(ev_q)) & ~$past(allowed)) == '0);

  // R3
  oe_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o & ~dir_pin) == '0);

  // R4
  od_no_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_o & odr_pin) == '0);

  // R10
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ev_q != '0 && msk_q != '0));

  // R11
  unmapped_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_wr |=> $stable(dir_q) && $stable(odr_q) && $stable(dat_q)
               && $stable(msk_q) && $stable(edg_q));
endmodule

bind gpio_ctl gpio_ctl_chk #(.NPINS(NPINS)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .pin_o    (pin_o),
  .pin_oe_o (pin_oe_o),
  .irq_o    (irq_o),
  .sync_q   (sync_q),
  .prev_q   (prev_q),
  .dir_q    (dir_q),
  .odr_q    (odr_q),
  .dat_q    (dat_q),
  .ev_q     (ev_q),
  .msk_q    (msk_q),
  .edg_q    (edg_q)
);

// File: tb/gpio_ctl_bench.sv
`timescale 1ns/1ps
module gpio_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = 5'h00;
  logic [31:0] wdata = '0, pin_drv = '0;
  logic [31:0] rdata, pin_out, pin_oe;
  logic        irq;

  int nchk = 0, nfail = 0;
  string tag = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gpio_ctl u_gpio_ctl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin_drv), .pin_o(pin_out),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_dir, m_odr, m_dat, m_ev, m_msk, m_edg;
  logic [31:0] hist[$];

  function automatic logic [31:0] rev(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = v[i];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_dir = '0; m_odr = '0; m_dat = '0; m_ev = '0; m_msk = '0; m_edg = '0;
      hist = {32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] s, p, det, w1c;
      s   = rev(hist[1]);
      p   = rev(hist[2]);
      det = (p & ~s) | (~p & s & ~m_edg);
      w1c = (req && we && addr == 5'h0C) ? wdata : '0;
      m_ev = (m_ev & ~w1c) | det;
      if (req && we) begin
        if (addr == 5'h00) m_dir = wdata;
        if (addr == 5'h04) m_odr = wdata;
        if (addr == 5'h08) m_dat = wdata;
        if (addr == 5'h10) m_msk = wdata;
        if (addr == 5'h14) m_edg = wdata;
      end
      hist.push_front(pin_drv);
      void'(hist.pop_back());
    end
  end

  function automatic logic [31:0] exp_rd();
    case (addr)
      5'h00: return m_dir;
      5'h04: return m_odr;
      5'h08: return (m_dat & m_dir) | (rev(hist[1]) & ~m_dir);
      5'h0C: return m_ev;
      5'h10: return m_msk;
      5'h14: return m_edg;
      default: return '0;
    endcase
  endfunction

  function automatic logic [31:0] exp_oe();
    logic [31:0] d, o, t, r;
    d = rev(m_dir); o = rev(m_odr); t = rev(m_dat);
    r = d & (o ? 32'h0 : 32'h0);
    for (int n = 0; n < 32; n++) r[n] = d[n] & (o[n] ? ~t[n] : 1'b1);
    return r;
  endfunction

  task automatic chk(input string t, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual %h expected %h", t, what, act, exp);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tag, "rdata", rdata, exp_rd());
      chk(tag, "pin_out", pin_out, rev(m_dat & ~m_odr));
      chk(tag, "pin_oe", pin_oe, exp_oe());
      chk(tag, "irq", {31'b0, irq}, {31'b0, |(m_ev & m_msk)});
    end
  end

  // ---------------- drivers ----------------
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1;
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic setpin(input logic [31:0] v);
    @(posedge clk); #1;
    pin_drv = v;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    nchk++; nfail++;
    $display("FAIL watchdog actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    // R1 reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "oe in reset", pin_oe, 32'h0);
    chk("R1", "irq in reset", {31'b0, irq}, 32'h0);
    #1 rst_n = 1'b1;
    for (int a = 0; a < 6; a++) begin
      rd(5'(a * 4), d);
      chk("R1", "reg after reset", d, 32'h0);
    end

    // R2, R3 push-pull outputs on pins 0,1; pin 1 high
    tag = "R3";
    wr(5'h00, 32'hC000_0000);
    wr(5'h08, 32'h4000_0000);
    @(negedge clk);
    chk("R2", "oe by pin number", pin_oe, 32'h0000_0003);
    chk("R3", "out by pin number", pin_out, 32'h0000_0002);

    // R4 open drain on pin 1
    tag = "R4";
    wr(5'h04, 32'h4000_0000);
    @(negedge clk);
    chk("R4", "od release oe", pin_oe, 32'h0000_0001);
    chk("R4", "od out", pin_out, 32'h0000_0000);
    wr(5'h08, 32'h0000_0000);
    @(negedge clk);
    chk("R4", "od drive-low oe", pin_oe, 32'h0000_0003);

    // R5 read-back mux: pins 4..7 high, pin 0 (output, latch 0) pad high
    tag = "R5";
    setpin(32'h0000_00F1);
    idle(3);
    rd(5'h08, d);
    chk("R5", "data read", d, 32'h0F00_0000);
    wr(5'h08, 32'h8000_0000);
    rd(5'h08, d);
    chk("R5", "data read latch", d, 32'h8F00_0000);
    wr(5'h0C, 32'hFFFF_FFFF);
    wr(5'h00, 32'h0);
    wr(5'h04, 32'h0);

    // R6 latency, any-edge on pin 10, all enabled
    tag = "R6";
    wr(5'h10, 32'hFFFF_FFFF);
    idle(2);
    wr(5'h0C, 32'hFFFF_FFFF);
    setpin(32'h0000_04F1);
    @(negedge clk);
    @(negedge clk);
    chk("R6", "irq one edge", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R6", "irq two edges", {31'b0, irq}, 32'h0);
    chk("R6", "pad visible", rdata & 32'h0020_0000, 32'h0);
    @(negedge clk);
    chk("R6", "irq three edges", {31'b0, irq}, 32'h1);
    idle(1);

    // R7 falling-only ignores a rise, catches a fall
    tag = "R7";
    wr(5'h14, 32'hFFFF_FFFF);
    wr(5'h0C, 32'hFFFF_FFFF);
    setpin(32'h0000_14F1);
    idle(4);
    rd(5'h0C, d);
    chk("R7", "rise ignored", d, 32'h0);
    setpin(32'h0000_04F1);
    idle(4);
    rd(5'h0C, d);
    chk("R7", "fall captured", d, 32'h0008_0000);
    wr(5'h14, 32'h0);
    setpin(32'h0000_24F1);
    idle(4);
    rd(5'h0C, d);
    chk("R7", "rise in any-edge", d, 32'h000C_0000);

    // R8 selective clear
    tag = "R8";
    wr(5'h0C, 32'h0008_0000);
    rd(5'h0C, d);
    chk("R8", "one cleared", d, 32'h0004_0000);
    wr(5'h0C, 32'h0);
    rd(5'h0C, d);
    chk("R8", "zero write no effect", d, 32'h0004_0000);
    wr(5'h0C, 32'hFFFF_FFFF);

    // R9 edge on pin 13 meets clear in the same cycle
    tag = "R9";
    setpin(32'h0000_04F1);
    @(posedge clk);
    wr(5'h0C, 32'h0004_0000);
    rd(5'h0C, d);
    chk("R9", "edge beats clear", d, 32'h0004_0000);

    // R10 enable gating
    tag = "R10";
    wr(5'h10, 32'h0);
    @(negedge clk);
    chk("R10", "masked", {31'b0, irq}, 32'h0);
    wr(5'h10, 32'h0000_0001);
    @(negedge clk);
    chk("R10", "other bit", {31'b0, irq}, 32'h0);
    wr(5'h10, 32'h0004_0000);
    @(negedge clk);
    chk("R10", "enabled", {31'b0, irq}, 32'h1);
    wr(5'h0C, 32'h0004_0000);
    @(negedge clk);
    chk("R10", "after clear", {31'b0, irq}, 32'h0);

    // R11 unmapped addresses
    tag = "R11";
    wr(5'h00, 32'h1234_5678);
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    rd(5'h18, d);
    chk("R11", "unmapped read", d, 32'h0);
    rd(5'h00, d);
    chk("R11", "dir untouched", d, 32'h1234_5678);
    rd(5'h14, d);
    chk("R11", "edge untouched", d, 32'h0);

    idle(2);
    finish_run();
  end
endmodule